// File: doc/BRIEF.md
# PPS-Latched Seconds/Ticks Timebase

This block keeps a 64-bit running time made of a seconds count and a ticks count. Ticks advance on every clock and roll over into seconds once per parameterised second. Software writes four write-only registers on a 32-bit settings bus: a pending seconds value, a pending ticks value, a configuration word and a load-command word. Writing the load command, which must come after the two pending values, moves the pending time into the running counters. The move happens either at once or on the next qualifying pulse-per-second edge.

Two pulse-per-second inputs are available: one from an external connector and one from a board-to-board link. Each passes through its own two-flop synchroniser and edge detector. The configuration word picks the input and the edge polarity. A small load controller has two states. In `ST_IDLE` no load is waiting. In `ST_ARMED` a load waits for the selected edge. The transitions are:
- `ST_IDLE -> ST_IDLE` on an immediate load command, which loads now.
- `ST_IDLE -> ST_ARMED` on a deferred load command.
- `ST_ARMED -> ST_IDLE` when the qualifying edge arrives (load) or when an immediate command arrives (load now).
- `ST_ARMED -> ST_ARMED` when a deferred command is repeated.

The current time is output as `{seconds, ticks}`, together with a one-cycle marker for each load.

Top module: `pps_timebase`

## Requirements
- R1: During reset and on the first cycle after it, the time output is 0 and the load marker is low. The configuration word resets to 0, and no load is waiting.
- R2: Without a load, ticks rise by 1 per clock. A ticks value at or above TICKS_PER_SEC-1 wraps to 0 on the next clock, and seconds then rise by 1.
- R3: The four registers sit at settings indices BASE_IDX+0 (pending seconds), +1 (pending ticks), +2 (configuration) and +3 (load command). A strobed write to any other index changes nothing.
- R4: A load-command write whose bit 0 is 1 puts the pending seconds and ticks on the time output in the cycle after the write edge. The value used is the pending value held before that edge.
- R5: A load-command write whose bit 0 is 0 arms a load. The load happens at the third clock edge after the selected input changes at a sampling edge: one edge samples the change, and two more pass through the synchroniser and edge detector.
- R6: Configuration bit 0 selects the edge: 0 is the falling edge and 1 is the rising edge. An edge of the other polarity does not load.
- R7: Configuration bit 1 selects the input: 0 is the connector input and 1 is the link input. Edges on the input that is not selected do not load.
- R8: An armed load is used by the first qualifying edge only. Later edges do not reload until another load command is written.
- R9: While no load is armed, PPS edges leave the counters running untouched.
- R10: The load marker is high exactly in the cycles whose time output was just loaded, and low in every other cycle.
- R11: An immediate load command written while a load is armed loads at once and cancels the armed load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Settings-bus write strobe |
| set_addr | input | ADDR_W | Settings register index |
| set_data | input | DATA_W | Settings write data |
| pps_ext | input | 1 | PPS from the external connector, asynchronous |
| pps_link | input | 1 | PPS from the board-to-board link, asynchronous |
| time_now | output | 2*DATA_W | Current time `{seconds, ticks}` |
| load_pulse | output | 1 | High for one cycle when the counters have just been loaded |

## Verification
An immediate load shows on `time_now` and `load_pulse` one clock after the edge that takes the load-command write. A deferred load shows one clock after the third edge following a change on the PPS input. That change is applied between edges, so the first of those three edges samples it. Register writes only affect a load at later edges. The bench drives every input on the falling clock edge and updates a behavioural model at the rising edge, using delay queues and integers. It then compares both outputs with the model on each falling edge, so every result is checked in the exact cycle it is due.

// File: rtl/ptime_pkg.sv
package ptime_pkg;

    // register offsets inside the bank; the load command must be last
    localparam int OFS_SECS  = 0;
    localparam int OFS_TICKS = 1;
    localparam int OFS_CFG   = 2;
    localparam int OFS_LOAD  = 3;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } load_state_e;

    typedef struct packed {
        logic src_link;   // bit 1: 0 connector input, 1 link input
        logic rise_sel;   // bit 0: 0 falling edge, 1 rising edge
    } pps_cfg_t;

endpackage

// File: rtl/ptime_regs.sv
module ptime_regs
    import ptime_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int BASE_IDX = 192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_stb,
    input  logic [ADDR_W-1:0] set_addr,
    input  logic [DATA_W-1:0] set_data,
    output logic [DATA_W-1:0] pend_secs,
    output logic [DATA_W-1:0] pend_ticks,
    output pps_cfg_t          cfg,
    output logic              latch_wr,
    output logic              latch_imm
);

    localparam logic [ADDR_W-1:0] A_SECS  = ADDR_W'(BASE_IDX + OFS_SECS);
    localparam logic [ADDR_W-1:0] A_TICKS = ADDR_W'(BASE_IDX + OFS_TICKS);
    localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(BASE_IDX + OFS_CFG);
    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(BASE_IDX + OFS_LOAD);

    logic hit_secs, hit_ticks, hit_cfg;

    always_comb begin
        hit_secs  = set_stb && (set_addr == A_SECS);
        hit_ticks = set_stb && (set_addr == A_TICKS);
        hit_cfg   = set_stb && (set_addr == A_CFG);
        latch_wr  = set_stb && (set_addr == A_LOAD);
        latch_imm = set_data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_secs  <= '0;
            pend_ticks <= '0;
            cfg        <= '0;
        end else begin
            if (hit_secs)  pend_secs  <= set_data;
            if (hit_ticks) pend_ticks <= set_data;
            if (hit_cfg)   cfg        <= pps_cfg_t'(set_data[1:0]);
        end
    end

endmodule

// File: rtl/ptime_pps_edge.sv
module ptime_pps_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pps_in,
    output logic rise_o,
    output logic fall_o
);

    localparam int LAST = SYNC_STAGES;

    // stages 0..SYNC_STAGES-1 synchronise, stage SYNC_STAGES holds the previous value
    logic [LAST:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[LAST-1:0], pps_in};
        end
    end

    always_comb begin
        rise_o =  pipe[LAST-1] & ~pipe[LAST];
        fall_o = ~pipe[LAST-1] &  pipe[LAST];
    end

endmodule

// File: rtl/ptime_load_fsm.sv
module ptime_load_fsm
    import ptime_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic latch_wr,
    input  logic latch_imm,
    input  logic pps_hit,
    output logic load_now,
    output logic armed,
    output logic load_pulse
);

    load_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (latch_wr && !latch_imm) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (latch_wr)     state_d = latch_imm ? ST_IDLE : ST_ARMED;
                else if (pps_hit) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load_now = 1'b0;
        armed    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_now = latch_wr && latch_imm;
            end
            ST_ARMED: begin
                armed    = 1'b1;
                load_now = latch_wr ? latch_imm : pps_hit;
            end
            default: load_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_pulse <= 1'b0;
        end else begin
            load_pulse <= load_now;
        end
    end

endmodule

// File: rtl/ptime_counter.sv
module ptime_counter #(
    parameter int          DATA_W = 32,
    parameter longint unsigned TPS = 100_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] ld_secs,
    input  logic [DATA_W-1:0] ld_ticks,
    output logic [DATA_W-1:0] secs,
    output logic [DATA_W-1:0] ticks
);

    localparam logic [DATA_W-1:0] TICK_LAST = DATA_W'(TPS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            secs  <= '0;
            ticks <= '0;
        end else if (load) begin
            secs  <= ld_secs;
            ticks <= ld_ticks;
        end else if (ticks >= TICK_LAST) begin
            ticks <= '0;
            secs  <= secs + 1'b1;
        end else begin
            ticks <= ticks + 1'b1;
        end
    end

endmodule

// File: rtl/pps_timebase.sv
module pps_timebase
    import ptime_pkg::*;
#(
    parameter int              ADDR_W        = 8,
    parameter int              DATA_W        = 32,
    parameter int              BASE_IDX      = 192,
    parameter int              SYNC_STAGES   = 2,
    parameter longint unsigned TICKS_PER_SEC = 100_000_000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                set_stb,
    input  logic [ADDR_W-1:0]   set_addr,
    input  logic [DATA_W-1:0]   set_data,
    input  logic                pps_ext,
    input  logic                pps_link,
    output logic [2*DATA_W-1:0] time_now,
    output logic                load_pulse
);

    localparam int N_PPS = 2;

    logic [DATA_W-1:0] pend_secs, pend_ticks;
    logic [DATA_W-1:0] cur_secs, cur_ticks;
    pps_cfg_t          cfg;
    logic              latch_wr, latch_imm;
    logic              load_now, armed, sel_edge;
    logic [N_PPS-1:0]  pps_raw, rise_v, fall_v;

    ptime_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .BASE_IDX (BASE_IDX)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .set_stb    (set_stb),
        .set_addr   (set_addr),
        .set_data   (set_data),
        .pend_secs  (pend_secs),
        .pend_ticks (pend_ticks),
        .cfg        (cfg),
        .latch_wr   (latch_wr),
        .latch_imm  (latch_imm)
    );

    assign pps_raw = {pps_link, pps_ext};

    for (genvar g = 0; g < N_PPS; g++) begin : g_pps
        ptime_pps_edge #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_edge (
            .clk    (clk),
            .rst    (rst),
            .pps_in (pps_raw[g]),
            .rise_o (rise_v[g]),
            .fall_o (fall_v[g])
        );
    end

    always_comb begin
        sel_edge = cfg.rise_sel ? rise_v[cfg.src_link] : fall_v[cfg.src_link];
    end

    ptime_load_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .latch_wr   (latch_wr),
        .latch_imm  (latch_imm),
        .pps_hit    (sel_edge),
        .load_now   (load_now),
        .armed      (armed),
        .load_pulse (load_pulse)
    );

    ptime_counter #(
        .DATA_W (DATA_W),
        .TPS    (TICKS_PER_SEC)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (load_now),
        .ld_secs  (pend_secs),
        .ld_ticks (pend_ticks),
        .secs     (cur_secs),
        .ticks    (cur_ticks)
    );

    assign time_now = {cur_secs, cur_ticks};

endmodule

// File: rtl/pps_timebase_chk.sv
module pps_timebase_chk #(
    parameter longint unsigned TPS = 100_000_000,
    parameter int              W   = 32
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] secs,
    input logic [W-1:0] ticks,
    input logic         load_now,
    input logic         load_pulse,
    input logic         armed,
    input logic         sel_edge,
    input logic         latch_wr,
    input logic         latch_imm,
    input logic [W-1:0] pend_secs,
    input logic [W-1:0] pend_ticks
);

    localparam logic [W-1:0] LAST = W'(TPS - 1);

    p_incr_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_now && ticks < LAST) |=> (ticks == $past(ticks) + 1'b1));

    p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (!load_now && ticks >= LAST) |=> (ticks == '0 && secs == $past(secs) + 1'b1));

    p_imm_load_r4: assert property (@(posedge clk) disable iff (rst)
        (latch_wr && latch_imm) |=> load_pulse);

    p_load_value_r10: assert property (@(posedge clk) disable iff (rst)
        load_pulse |-> ({secs, ticks} == $past({pend_secs, pend_ticks})));

    p_armed_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && sel_edge && !latch_wr) |=> load_pulse);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!armed && !latch_wr) |=> !load_pulse);

endmodule

bind pps_timebase pps_timebase_chk #(
    .TPS (TICKS_PER_SEC),
    .W   (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .secs       (cur_secs),
    .ticks      (cur_ticks),
    .load_now   (load_now),
    .load_pulse (load_pulse),
    .armed      (armed),
    .sel_edge   (sel_edge),
    .latch_wr   (latch_wr),
    .latch_imm  (latch_imm),
    .pend_secs  (pend_secs),
    .pend_ticks (pend_ticks)
);

// File: tb/test_pps_timebase.sv
module test_pps_timebase;

    localparam int CLK_PERIOD = 10;
    localparam int TPS        = 16;
    localparam int BASE       = 192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        set_stb = 1'b0;
    logic [7:0]  set_addr = '0;
    logic [31:0] set_data = '0;
    logic        pps_ext = 1'b0;
    logic        pps_link = 1'b0;
    logic [63:0] time_now;
    logic        load_pulse;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";
    bit    checking = 1'b0;
    bit    done     = 1'b0;

    pps_timebase #(
        .BASE_IDX      (BASE),
        .TICKS_PER_SEC (TPS)
    ) i_pps_timebase (
        .clk        (clk),
        .rst        (rst),
        .set_stb    (set_stb),
        .set_addr   (set_addr),
        .set_data   (set_data),
        .pps_ext    (pps_ext),
        .pps_link   (pps_link),
        .time_now   (time_now),
        .load_pulse (load_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference
    longint unsigned m_secs, m_ticks, p_secs, p_ticks;
    int  m_flags;
    bit  m_armed, m_pulse;
    bit  q_ext[$], q_link[$];   // delay queues: index 0 newest sample

    task automatic model_reset();
        m_secs = 0; m_ticks = 0; p_secs = 0; p_ticks = 0;
        m_flags = 0; m_armed = 0; m_pulse = 0;
        q_ext  = '{0, 0, 0};
        q_link = '{0, 0, 0};
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (rst) begin
            model_reset();
        end else begin
            bit cur, prv, hit, do_load;
            if ((m_flags & 2) != 0) begin cur = q_link[1]; prv = q_link[2]; end
            else                    begin cur = q_ext[1];  prv = q_ext[2];  end
            hit = ((m_flags & 1) != 0) ? (cur && !prv) : (!cur && prv);
            do_load = 0;
            if (set_stb && set_addr == BASE + 3) begin
                if (set_data[0]) begin do_load = 1; m_armed = 0; end
                else m_armed = 1;
            end else if (m_armed && hit) begin
                do_load = 1; m_armed = 0;
            end
            if (do_load) begin
                m_secs = p_secs; m_ticks = p_ticks;
            end else if (m_ticks >= TPS - 1) begin
                m_ticks = 0; m_secs = (m_secs + 1) % 64'h1_0000_0000;
            end else begin
                m_ticks = m_ticks + 1;
            end
            m_pulse = do_load;
            if (set_stb && set_addr == BASE + 0) p_secs  = set_data;
            if (set_stb && set_addr == BASE + 1) p_ticks = set_data;
            if (set_stb && set_addr == BASE + 2) m_flags = int'(set_data[1:0]);
            q_ext.push_front(pps_ext);   void'(q_ext.pop_back());
            q_link.push_front(pps_link); void'(q_link.pop_back());
        end
    end

    task automatic check(input string req, input logic [63:0] act_t, input logic act_p,
                         input logic [63:0] exp_t, input logic exp_p);
        n_checks++;
        if (act_t !== exp_t || act_p !== exp_p) begin
            n_fails++;
            $display("FAIL %s: time_now=%h load_pulse=%b, expected time_now=%h load_pulse=%b",
                     req, act_t, act_p, exp_t, exp_p);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !rst)
            check(cur_req, time_now, load_pulse, {m_secs[31:0], m_ticks[31:0]}, m_pulse);
    end

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        set_stb = 1'b1; set_addr = 8'(idx); set_data = d;
        @(negedge clk);
        set_stb = 1'b0; set_addr = '0; set_data = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, during reset and just after
        idle(3);
        check("R1", time_now, load_pulse, 64'd0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", time_now, load_pulse, 64'd1, 1'b0);
        checking = 1'b1;

        // R2: free running with several wraps
        cur_req = "R2"; idle(40);

        // R4 / R10: immediate load
        cur_req = "R4"; wr(BASE + 0, 32'd5); wr(BASE + 1, 32'd3); wr(BASE + 3, 32'd1); idle(6);
        cur_req = "R10"; wr(BASE + 1, 32'd9); wr(BASE + 3, 32'h1); wr(BASE + 3, 32'h1); idle(3);

        // R2 corner: loaded ticks above the limit wrap on the next clock
        cur_req = "R2"; wr(BASE + 0, 32'hFFFF_FFFF); wr(BASE + 1, 32'd40); wr(BASE + 3, 32'd1); idle(20);

        // R3: writes outside the bank do nothing, pending values unchanged
        cur_req = "R3"; wr(BASE + 0, 32'd77); wr(BASE + 1, 32'd2);
        wr(BASE + 4, 32'h1); wr(BASE - 1, 32'h1); wr(0, 32'hDEAD_BEEF); idle(4);
        wr(BASE + 3, 32'd1); idle(4);

        // R9: PPS edges without an armed load
        cur_req = "R9";
        repeat (3) begin pps_ext = 1'b1; idle(4); pps_ext = 1'b0; idle(4); end

        // R5 / R6: falling edge on connector input (config 0)
        cur_req = "R5"; wr(BASE + 0, 32'd100); wr(BASE + 1, 32'd0); wr(BASE + 3, 32'd0);
        pps_ext = 1'b1; idle(6);
        cur_req = "R6"; pps_ext = 1'b0; idle(6);

        // R8: later edges do not reload
        cur_req = "R8";
        repeat (2) begin pps_ext = 1'b1; idle(4); pps_ext = 1'b0; idle(4); end

        // R6: rising edge selected
        cur_req = "R6"; wr(BASE + 2, 32'd1); wr(BASE + 0, 32'd200); wr(BASE + 3, 32'd0);
        idle(3); pps_ext = 1'b1; idle(6); pps_ext = 1'b0; idle(6);

        // R7: link input selected, connector edges ignored
        cur_req = "R7"; wr(BASE + 2, 32'd3); wr(BASE + 0, 32'd300); wr(BASE + 3, 32'd0);
        pps_ext = 1'b1; idle(5); pps_ext = 1'b0; idle(5);
        pps_link = 1'b1; idle(6); pps_link = 1'b0; idle(6);

        // R11: immediate command while armed cancels the armed load
        cur_req = "R11"; wr(BASE + 0, 32'd400); wr(BASE + 3, 32'd0); idle(2);
        wr(BASE + 0, 32'd500); wr(BASE + 3, 32'd1); idle(3);
        pps_link = 1'b1; idle(6); pps_link = 1'b0; idle(6);

        // R5: re-arm after cancel, load on link rising edge
        cur_req = "R5"; wr(BASE + 0, 32'd600); wr(BASE + 1, 32'd7); wr(BASE + 3, 32'd0);
        pps_link = 1'b1; idle(6); pps_link = 1'b0; idle(6);

        finish_run();
    end

endmodule